// File: doc/BRIEF.md
# Interrupt and Trap Sequencer

This block decides, each time the execution engine finishes an instruction, whether control must be diverted to a service routine. It watches level-sensitive interrupt requests from bus devices, a power-fail input and the trace bit of the processor status word. It owns the program counter and the status word. The status word holds four condition flags, a trace bit and a three-bit priority level that masks device requests.

When a source is taken, the sequencer pushes the old status word and then the next-instruction address onto the stack below the incoming stack pointer. It then loads a new PC and a new status word from a pair of words in low memory, at an address fixed by the source. Every memory access waits for an acknowledge. A single-cycle done strobe tells the execution engine that it may continue, and at that point the PC, status word and updated stack pointer are valid. When no source is taken, the done strobe follows the boundary without any memory traffic.

Status word layout: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 trace, bits 7:5 priority, bits 15:8 always zero. Device `i` has fixed priority `PRIO_BASE+i` (4..7 by default) and vector `DEV_VEC_BASE+4*i` (octal 100, 104, 110, 114 by default). Power-fail uses vector octal 24 and the trace trap uses vector octal 14.

Top module: `irq_trap_seq`

## Requirements
- R1: After reset, pc_out equals RESET_PC (0), psw_out is 0, and mem_req, seq_done and dev_ack are all low.
- R2: Bits 15:8 of psw_out always read zero, whether the status word was loaded through psw_wr or from a vector word.
- R3: A pending request never starts memory traffic by itself. mem_req first rises only in the cycle after an instr_done strobe.
- R4: A device request is taken only when the device's fixed priority is strictly greater than psw_out[7:5]. Otherwise the boundary completes with no memory access, the PC becomes next_pc and the request stays pending.
- R5: A rising edge on pwr_fail is remembered and serviced at the next boundary through vector octal 24, whatever the priority field holds.
- R6: When psw_out[4] (trace) is 1 at a boundary, a trap through vector octal 14 is taken, and the saved status word still has the trace bit set.
- R7: Pending sources are resolved in the order power-fail, then trace, then devices from highest to lowest fixed priority.
- R8: A service writes the status word to address sp_in-2, then next_pc to sp_in-4. It then reads the new PC from the vector address and the new status word from vector+2. At done it pulses sp_wr with sp_out = sp_in-4.
- R9: While mem_req is high and mem_ack is low, mem_req, mem_addr, mem_we and mem_wdata hold steady. Any number of wait cycles gives the same accesses.
- R10: seq_done pulses for exactly one cycle per instr_done. It comes one cycle after the boundary when nothing is taken, and one cycle after the last acknowledge otherwise.
- R11: A serviced device i receives a one-cycle pulse on dev_ack[i] only, and its vector is DEV_VEC_BASE+4*i. Device 0, the keyboard receiver, uses octal 100.
- R12: On a boundary with nothing taken, pc_out takes the value of next_pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_DEV | Level interrupt requests, bit i from device i |
| pwr_fail | input | 1 | Power-fail indication, edge-captured |
| instr_done | input | 1 | Instruction-boundary strobe from the execution engine |
| next_pc | input | DW | Address of the next instruction, valid with instr_done |
| psw_wr | input | 1 | Status word write from the execution engine (ignored while busy) |
| psw_wdata | input | DW | Status word write data |
| sp_in | input | DW | Current stack pointer (R6) |
| pc_out | output | DW | Program counter (R7) |
| psw_out | output | DW | Processor status word |
| sp_out | output | DW | Stack pointer after the pushes |
| sp_wr | output | 1 | Pulse: write sp_out back to R6 |
| seq_done | output | 1 | Pulse: boundary handling complete |
| dev_ack | output | NUM_DEV | One-hot pulse naming the serviced device |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | DW | Byte address of the word accessed |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
The sequencer is driven through boundaries with no source pending, with a single device above and at the priority level, and with power-fail, trace and two devices all pending together. The first case separates the plain PC hand-over from a service. The level comparison shows whether the priority check is strict. The stacked case fixes the resolution order one service at a time. Reserved status bits are forced high both through a direct write and inside a vector word, so either load path that leaks them is caught. The same service is repeated with acknowledge wait states, which shows whether the access sequence and its stall behaviour depend on memory latency.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_PSW,
      ST_PUSH_PC,
      ST_RD_PC,
      ST_RD_PSW,
      ST_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_PWR,
      SRC_TRACE,
      SRC_DEV
   } src_t;

   localparam int PSW_TRACE_BIT = 4;
   localparam int PSW_PRIO_LSB  = 5;
   localparam int PSW_PRIO_W    = 3;
   localparam int PSW_USED_BITS = 8;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_seq_pkg::*;
#(
   parameter int DW           = 16,
   parameter int NUM_DEV      = 4,
   parameter int PRIO_BASE    = 4,
   parameter int DEV_VEC_BASE = 'o100,
   parameter int PF_VEC       = 'o24,
   parameter int TR_VEC       = 'o14,
   parameter bit HAS_TRACE    = 1'b1
) (
   input  logic                  pf_pend,
   input  logic                  trace_bit,
   input  logic [NUM_DEV-1:0]    dev_req,
   input  logic [PSW_PRIO_W-1:0] cur_prio,
   output logic                  take,
   output src_t                  src,
   output logic [DW-1:0]         vec,
   output logic [NUM_DEV-1:0]    dev_sel
);

   logic [NUM_DEV-1:0] elig;
   logic [NUM_DEV-1:0] win_onehot;
   logic [DW-1:0]      dev_vec;
   logic               dev_any;
   logic               trace_hit;

   generate
      for (genvar g = 0; g < NUM_DEV; g++) begin : g_elig
         localparam int LVL = PRIO_BASE + g;
         assign elig[g] = dev_req[g] && (PSW_PRIO_W'(LVL) > cur_prio);
      end
      if (HAS_TRACE) begin : g_trace
         assign trace_hit = trace_bit;
      end else begin : g_no_trace
         assign trace_hit = 1'b0;
      end
   endgenerate

   // higher index carries higher fixed priority, so the last hit wins
   always_comb begin
      win_onehot = '0;
      dev_vec    = '0;
      dev_any    = 1'b0;
      for (int i = 0; i < NUM_DEV; i++) begin
         if (elig[i]) begin
            win_onehot    = '0;
            win_onehot[i] = 1'b1;
            dev_vec       = DW'(DEV_VEC_BASE + 4 * i);
            dev_any       = 1'b1;
         end
      end
   end

   always_comb begin
      src = SRC_NONE;
      vec = '0;
      if (pf_pend) begin
         src = SRC_PWR;
         vec = DW'(PF_VEC);
      end else if (trace_hit) begin
         src = SRC_TRACE;
         vec = DW'(TR_VEC);
      end else if (dev_any) begin
         src = SRC_DEV;
         vec = dev_vec;
      end
   end

   assign take    = (src != SRC_NONE);
   assign dev_sel = (src == SRC_DEV) ? win_onehot : '0;

endmodule

// File: rtl/irq_pc_psw.sv
module irq_pc_psw
   import irq_seq_pkg::*;
#(
   parameter int          DW       = 16,
   parameter logic [15:0] RESET_PC = 16'h0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pc_from_exec,
   input  logic [DW-1:0] next_pc,
   input  logic          pc_from_mem,
   input  logic          psw_from_mem,
   input  logic [DW-1:0] mem_rdata,
   input  logic          psw_from_exec,
   input  logic [DW-1:0] psw_wdata,
   output logic [DW-1:0] pc_q,
   output logic [DW-1:0] psw_q
);

   localparam logic [DW-1:0] USED_MASK = DW'((1 << PSW_USED_BITS) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= DW'(RESET_PC);
         psw_q <= '0;
      end else begin
         if (pc_from_exec)
            pc_q <= next_pc;
         else if (pc_from_mem)
            pc_q <= mem_rdata;

         if (psw_from_mem)
            psw_q <= mem_rdata & USED_MASK;
         else if (psw_from_exec)
            psw_q <= psw_wdata & USED_MASK;
      end
   end

endmodule

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
   import irq_seq_pkg::*;
#(
   parameter int DW      = 16,
   parameter int NUM_DEV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_done,
   input  logic               take,
   input  src_t               src,
   input  logic [DW-1:0]      vec,
   input  logic [NUM_DEV-1:0] dev_sel,
   input  logic [DW-1:0]      sp_in,
   input  logic [DW-1:0]      psw_q,
   input  logic [DW-1:0]      pc_q,
   input  logic               mem_ack,
   output logic               idle,
   output logic               pf_clr,
   output logic               ld_pc,
   output logic               ld_psw,
   output logic               mem_req,
   output logic               mem_we,
   output logic [DW-1:0]      mem_addr,
   output logic [DW-1:0]      mem_wdata,
   output logic               seq_done,
   output logic               sp_wr,
   output logic [DW-1:0]      sp_out,
   output logic [NUM_DEV-1:0] dev_ack
);

   localparam logic [DW-1:0] WORD_STEP = DW'(2);

   seq_state_t         state, state_nx;
   logic [DW-1:0]      sp_work;
   logic [DW-1:0]      vec_q;
   logic               svc_q;
   logic [NUM_DEV-1:0] ack_q;
   logic               accept;
   logic               step;

   assign idle   = (state == ST_IDLE);
   assign accept = idle && instr_done && take;
   assign step   = mem_req && mem_ack;
   assign pf_clr = accept && (src == SRC_PWR);

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:     if (instr_done) state_nx = take ? ST_PUSH_PSW : ST_DONE;
         ST_PUSH_PSW: if (mem_ack) state_nx = ST_PUSH_PC;
         ST_PUSH_PC:  if (mem_ack) state_nx = ST_RD_PC;
         ST_RD_PC:    if (mem_ack) state_nx = ST_RD_PSW;
         ST_RD_PSW:   if (mem_ack) state_nx = ST_DONE;
         ST_DONE:     state_nx = ST_IDLE;
         default:     state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sp_work <= '0;
         vec_q   <= '0;
         svc_q   <= 1'b0;
         ack_q   <= '0;
      end else begin
         state <= state_nx;
         ack_q <= accept ? dev_sel : '0;
         if (idle && instr_done) begin
            svc_q   <= take;
            sp_work <= sp_in;
            vec_q   <= vec;
         end else if (step && mem_we) begin
            sp_work <= sp_work - WORD_STEP;
         end
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_PUSH_PSW: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_work - WORD_STEP;
            mem_wdata = psw_q;
         end
         ST_PUSH_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_work - WORD_STEP;
            mem_wdata = pc_q;
         end
         ST_RD_PC: begin
            mem_req  = 1'b1;
            mem_addr = vec_q;
         end
         ST_RD_PSW: begin
            mem_req  = 1'b1;
            mem_addr = vec_q + WORD_STEP;
         end
         default: ;
      endcase
   end

   assign ld_pc    = (state == ST_RD_PC) && mem_ack;
   assign ld_psw   = (state == ST_RD_PSW) && mem_ack;
   assign seq_done = (state == ST_DONE);
   assign sp_wr    = seq_done && svc_q;
   assign sp_out   = sp_work;
   assign dev_ack  = ack_q;

   // R3: memory traffic only ever begins right after a boundary strobe
   p_start_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(instr_done))
      else $error("memory access started without a boundary");

   // R9: an unacknowledged access holds all of its fields
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)))
      else $error("access changed while waiting for acknowledge");

   // R10: done is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done)
      else $error("done held longer than one cycle");

endmodule

// File: rtl/irq_trap_seq.sv
module irq_trap_seq
   import irq_seq_pkg::*;
#(
   parameter int          DW           = 16,
   parameter int          NUM_DEV      = 4,
   parameter int          PRIO_BASE    = 4,
   parameter int          DEV_VEC_BASE = 'o100,
   parameter int          PF_VEC       = 'o24,
   parameter int          TR_VEC       = 'o14,
   parameter bit          HAS_TRACE    = 1'b1,
   parameter logic [15:0] RESET_PC     = 16'h0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] dev_req,
   input  logic               pwr_fail,
   input  logic               instr_done,
   input  logic [DW-1:0]      next_pc,
   input  logic               psw_wr,
   input  logic [DW-1:0]      psw_wdata,
   input  logic [DW-1:0]      sp_in,
   output logic [DW-1:0]      pc_out,
   output logic [DW-1:0]      psw_out,
   output logic [DW-1:0]      sp_out,
   output logic               sp_wr,
   output logic               seq_done,
   output logic [NUM_DEV-1:0] dev_ack,
   output logic               mem_req,
   output logic               mem_we,
   output logic [DW-1:0]      mem_addr,
   output logic [DW-1:0]      mem_wdata,
   input  logic [DW-1:0]      mem_rdata,
   input  logic               mem_ack
);

   localparam int TOP_LVL = PRIO_BASE + NUM_DEV - 1;

   generate
      if (DW < 16 || (DW % 8) != 0) begin : g_bad_dw
         $error("DW must be a multiple of 8 and at least 16");
      end
      if (NUM_DEV < 1 || TOP_LVL > 7) begin : g_bad_dev
         $error("device priorities must fit the 3-bit priority field");
      end
   endgenerate

   logic                  idle, pf_clr, ld_pc, ld_psw;
   logic                  take;
   src_t                  src;
   logic [DW-1:0]         vec;
   logic [NUM_DEV-1:0]    dev_sel;
   logic [DW-1:0]         pc_q, psw_q;
   logic                  pf_q, pf_pend;
   logic [PSW_PRIO_W-1:0] cur_prio;

   assign cur_prio = psw_q[PSW_PRIO_LSB +: PSW_PRIO_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_q    <= 1'b0;
         pf_pend <= 1'b0;
      end else begin
         pf_q    <= pwr_fail;
         pf_pend <= (pf_pend && !pf_clr) || (pwr_fail && !pf_q);
      end
   end

   irq_arbiter #(
      .DW(DW), .NUM_DEV(NUM_DEV), .PRIO_BASE(PRIO_BASE),
      .DEV_VEC_BASE(DEV_VEC_BASE), .PF_VEC(PF_VEC), .TR_VEC(TR_VEC),
      .HAS_TRACE(HAS_TRACE)
   ) u_arb (
      .pf_pend   (pf_pend),
      .trace_bit (psw_q[PSW_TRACE_BIT]),
      .dev_req   (dev_req),
      .cur_prio  (cur_prio),
      .take      (take),
      .src       (src),
      .vec       (vec),
      .dev_sel   (dev_sel)
   );

   irq_pc_psw #(.DW(DW), .RESET_PC(RESET_PC)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .pc_from_exec  (idle && instr_done),
      .next_pc       (next_pc),
      .pc_from_mem   (ld_pc),
      .psw_from_mem  (ld_psw),
      .mem_rdata     (mem_rdata),
      .psw_from_exec (idle && psw_wr),
      .psw_wdata     (psw_wdata),
      .pc_q          (pc_q),
      .psw_q         (psw_q)
   );

   irq_ctx_fsm #(.DW(DW), .NUM_DEV(NUM_DEV)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_done (instr_done),
      .take       (take),
      .src        (src),
      .vec        (vec),
      .dev_sel    (dev_sel),
      .sp_in      (sp_in),
      .psw_q      (psw_q),
      .pc_q       (pc_q),
      .mem_ack    (mem_ack),
      .idle       (idle),
      .pf_clr     (pf_clr),
      .ld_pc      (ld_pc),
      .ld_psw     (ld_psw),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .seq_done   (seq_done),
      .sp_wr      (sp_wr),
      .sp_out     (sp_out),
      .dev_ack    (dev_ack)
   );

   assign pc_out  = pc_q;
   assign psw_out = psw_q;

   // fixed priority of the acknowledged device, for the checks below
   logic [PSW_PRIO_W-1:0] ack_lvl;
   always_comb begin
      ack_lvl = '0;
      for (int i = 0; i < NUM_DEV; i++)
         if (dev_ack[i]) ack_lvl = PSW_PRIO_W'(PRIO_BASE + i);
   end

   // R11: at most one device is acknowledged at a time
   p_ack_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_ack))
      else $error("several devices acknowledged");

   // R4: an acknowledged device outranked the level in force at the boundary
   p_dev_above_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_ack) |-> (ack_lvl > $past(cur_prio)))
      else $error("device serviced at or below the current level");

endmodule

// File: tb/test_irq_trap_seq.sv
module test_irq_trap_seq;

   localparam int DW = 16;
   localparam int ND = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [ND-1:0] dev_req = '0;
   logic          pwr_fail = 1'b0;
   logic          instr_done = 1'b0;
   logic [DW-1:0] next_pc = '0;
   logic          psw_wr = 1'b0;
   logic [DW-1:0] psw_wdata = '0;
   logic [DW-1:0] sp_in = 16'h0100;
   logic [DW-1:0] pc_out, psw_out, sp_out, mem_addr, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          sp_wr, seq_done, mem_req, mem_we;
   logic          mem_ack = 1'b0;
   logic [ND-1:0] dev_ack;

   irq_trap_seq i_irq_trap_seq (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .pwr_fail(pwr_fail),
      .instr_done(instr_done), .next_pc(next_pc), .psw_wr(psw_wr),
      .psw_wdata(psw_wdata), .sp_in(sp_in), .pc_out(pc_out), .psw_out(psw_out),
      .sp_out(sp_out), .sp_wr(sp_wr), .seq_done(seq_done), .dev_ack(dev_ack),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model with programmable wait states
   logic [DW-1:0] mem [0:255];
   int            wait_states = 0;
   int            wcnt = 0;
   logic [DW-1:0] wr_addr [0:7];
   logic [DW-1:0] wr_data [0:7];
   logic [DW-1:0] rd_addr [0:7];
   int            n_wr = 0;
   int            n_rd = 0;

   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         if (wcnt == wait_states) begin
            mem_ack <= 1'b1;
            wcnt    <= 0;
            if (mem_we) begin
               mem[mem_addr[8:1]] <= mem_wdata;
               if (n_wr < 8) begin wr_addr[n_wr] = mem_addr; wr_data[n_wr] = mem_wdata; end
               n_wr++;
            end else begin
               mem_rdata <= mem[mem_addr[8:1]];
               if (n_rd < 8) rd_addr[n_rd] = mem_addr;
               n_rd++;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // stall monitor
   bit            was_waiting = 1'b0;
   logic [DW-1:0] held_addr, held_wdata;
   logic          held_we;
   int            stall_viol = 0;
   always @(posedge clk) begin
      if (was_waiting && (!mem_req || mem_addr != held_addr || mem_wdata != held_wdata
                          || mem_we != held_we))
         stall_viol++;
      was_waiting = mem_req && !mem_ack;
      held_addr   = mem_addr;
      held_wdata  = mem_wdata;
      held_we     = mem_we;
   end

   // output monitors
   int            done_total = 0;
   int            req_starts = 0;
   int            sp_wr_cnt = 0;
   logic [DW-1:0] sp_seen = '0;
   logic [ND-1:0] ack_seen = '0;
   logic          req_prev = 1'b0;
   always @(negedge clk) begin
      if (seq_done) done_total++;
      if (sp_wr) begin sp_wr_cnt++; sp_seen = sp_out; end
      if (mem_req && !req_prev) req_starts++;
      req_prev = mem_req;
      ack_seen = ack_seen | dev_ack;
      for (int i = 0; i < ND; i++) if (dev_ack[i]) dev_req[i] = 1'b0;
   end

   task automatic clear_log();
      n_wr = 0; n_rd = 0; ack_seen = '0; sp_wr_cnt = 0; sp_seen = '0;
   endtask

   task automatic set_psw(input logic [DW-1:0] v);
      @(negedge clk); psw_wr = 1'b1; psw_wdata = v;
      @(negedge clk); psw_wr = 1'b0;
   endtask

   task automatic do_instr(input logic [DW-1:0] npc, input string tag);
      int start;
      start = done_total;
      @(negedge clk); instr_done = 1'b1; next_pc = npc;
      @(negedge clk); instr_done = 1'b0;
      for (int k = 0; k < 300; k++) begin
         #1;
         if (done_total != start) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      #1;
      chk(done_total == start + 1, {tag, " R10 one done pulse"}, done_total - start, 1);
   endtask

   // check a full service record: R8 ordering and addresses
   task automatic chk_service(input logic [DW-1:0] old_psw, input logic [DW-1:0] npc,
                              input logic [DW-1:0] v, input string tag);
      chk(n_wr == 2 && n_rd == 2, {tag, " R8 access count"}, {n_wr[15:0], n_rd[15:0]}, 32'h0002_0002);
      chk(wr_addr[0] == 16'h00FE && wr_data[0] == old_psw, {tag, " R8 psw push"},
          {wr_addr[0], wr_data[0]}, {16'h00FE, old_psw});
      chk(wr_addr[1] == 16'h00FC && wr_data[1] == npc, {tag, " R8 pc push"},
          {wr_addr[1], wr_data[1]}, {16'h00FC, npc});
      chk(rd_addr[0] == v && rd_addr[1] == v + 2, {tag, " R8 vector reads"},
          {rd_addr[0], rd_addr[1]}, {v, v + 16'd2});
      chk(sp_wr_cnt == 1 && sp_seen == 16'h00FC, {tag, " R8 stack pointer"}, sp_seen, 16'h00FC);
   endtask

   task automatic t_reset();
      chk(pc_out == 16'h0000, "R1 pc", pc_out, 0);
      chk(psw_out == 16'h0000, "R1 psw", psw_out, 0);
      chk(!mem_req && !seq_done && dev_ack == '0, "R1 idle outputs",
          {mem_req, seq_done, dev_ack}, 0);
   endtask

   task automatic t_plain();
      clear_log();
      do_instr(16'h1002, "plain");
      chk(pc_out == 16'h1002, "R12 pc from next_pc", pc_out, 16'h1002);
      chk(n_wr == 0 && n_rd == 0, "R12 no memory traffic", n_wr + n_rd, 0);
   endtask

   task automatic t_psw_rsvd();
      set_psw(16'hFFFF);
      #1;
      chk(psw_out == 16'h00FF, "R2 reserved bits via write", psw_out, 16'h00FF);
      set_psw(16'h0000);
   endtask

   task automatic t_boundary_keyboard();
      int s0;
      clear_log();
      mem[32] = 16'h0600; mem[33] = 16'hFF05;
      s0 = req_starts;
      @(negedge clk); dev_req[0] = 1'b1;
      repeat (6) @(negedge clk);
      #1;
      chk(req_starts == s0 && !mem_req, "R3 no access before boundary", req_starts - s0, 0);
      do_instr(16'h2000, "kbd");
      chk_service(16'h0000, 16'h2000, 16'o100, "kbd");
      chk(pc_out == 16'h0600, "R11 keyboard vector pc", pc_out, 16'h0600);
      chk(psw_out == 16'h0005, "R2 reserved bits via vector", psw_out, 16'h0005);
      chk(ack_seen == 4'b0001, "R11 ack one-hot", ack_seen, 4'b0001);
   endtask

   task automatic t_masked();
      clear_log();
      mem[38] = 16'h0400; mem[39] = 16'hFFE0;
      set_psw(16'h00E0);
      @(negedge clk); dev_req[3] = 1'b1;
      do_instr(16'h3000, "masked");
      chk(pc_out == 16'h3000 && n_wr == 0 && n_rd == 0, "R4 equal level not taken",
          pc_out, 16'h3000);
      chk(dev_req[3] == 1'b1 && ack_seen == '0, "R4 request left pending", ack_seen, 0);
      set_psw(16'h00C0);
      clear_log();
      do_instr(16'h3002, "lvl6");
      chk_service(16'h00C0, 16'h3002, 16'o114, "lvl6");
      chk(pc_out == 16'h0400 && ack_seen == 4'b1000, "R4 higher device taken",
          {pc_out, 12'h0, ack_seen}, {16'h0400, 16'h0008});
   endtask

   task automatic t_order();
      mem[10] = 16'h0300; mem[11] = 16'h0010;
      mem[6]  = 16'h0500; mem[7]  = 16'h0000;
      mem[34] = 16'h0700; mem[35] = 16'h0000;
      set_psw(16'h00F0);
      @(negedge clk); dev_req[3] = 1'b1; dev_req[1] = 1'b1; pwr_fail = 1'b1;
      repeat (2) @(negedge clk); pwr_fail = 1'b0;
      clear_log();
      do_instr(16'h4000, "pf");
      chk_service(16'h00F0, 16'h4000, 16'o24, "pf");
      chk(pc_out == 16'h0300, "R5 power-fail ignores level", pc_out, 16'h0300);
      chk(ack_seen == '0, "R7 power-fail before trace and devices", ack_seen, 0);
      clear_log();
      do_instr(16'h4002, "trace");
      chk_service(16'h0010, 16'h4002, 16'o14, "trace");
      chk(pc_out == 16'h0500 && psw_out == 16'h0000, "R6 trace trap vector",
          {pc_out, psw_out}, {16'h0500, 16'h0000});
      chk(ack_seen == '0, "R7 trace before devices", ack_seen, 0);
      clear_log();
      do_instr(16'h4004, "dev3");
      chk(ack_seen == 4'b1000 && pc_out == 16'h0400, "R7 highest device first",
          {pc_out, 12'h0, ack_seen}, {16'h0400, 16'h0008});
      set_psw(16'h0000);
      clear_log();
      do_instr(16'h4006, "dev1");
      chk_service(16'h0000, 16'h4006, 16'o104, "dev1");
      chk(ack_seen == 4'b0010 && pc_out == 16'h0700, "R11 device 1 vector",
          {pc_out, 12'h0, ack_seen}, {16'h0700, 16'h0002});
   endtask

   task automatic t_waits();
      mem[36] = 16'h0800; mem[37] = 16'h0003;
      wait_states = 3;
      clear_log();
      @(negedge clk); dev_req[2] = 1'b1;
      do_instr(16'h5000, "wait");
      chk_service(16'h0000, 16'h5000, 16'o110, "wait");
      chk(pc_out == 16'h0800 && psw_out == 16'h0003, "R9 result with wait states",
          {pc_out, psw_out}, {16'h0800, 16'h0003});
      chk(stall_viol == 0, "R9 fields held while stalled", stall_viol, 0);
      wait_states = 0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_plain();
      t_psw_rsvd();
      t_boundary_keyboard();
      t_masked();
      t_order();
      t_waits();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule